// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block is a parameterised general-purpose I/O port that a processor operates through a small register window. A single-cycle bus reaches four word registers: the output latch, an atomic set register, an atomic clear register and a direction register. The port drives an output-enable vector and an output-value vector toward the pad ring. It samples the pad input vector through a two-stage synchroniser.

Several build-time parameters shape the port. The set register can be absent, can work alone as a whole-latch load, or can be paired with a clear register for atomic bit updates. The direction register can be absent, can mark outputs with a 1, or can mark inputs with a 1. Pin 0 can sit on the least or the most significant register bit. The register width is 8, 16, 32 or 64, and the port has one pin per register bit.

Top module: `gpio_mmio_ctrl`

## Requirements
- R1: After reset the output latch is zero, every pin is an input (pad_oe all zero when a direction register exists), and pad_out is all zero.
- R2: A write to offset 0 loads the whole output latch in one cycle, and pad_out shows the new value after that clock edge. When no write is made, the latch holds its value.
- R3: A read of offset 0 returns, for each bit, the latch value if that pin is an output, or the pad level sampled through two flip-flops if the pin is an input. A pad change therefore becomes visible after the second rising edge.
- R4: With SET_MODE=2, writing offset 1 sets every latch bit whose write bit is 1 and writing offset 2 clears every latch bit whose write bit is 1. Bits written as 0 keep their value.
- R5: With SET_MODE=1, writing offset 1 loads the whole latch with the written word, driving both ones and zeros, and writes to offset 2 leave the latch unchanged.
- R6: With SET_MODE=0, writes to offsets 1 and 2 leave the latch unchanged.
- R7: Reads of offsets 1 and 2 return the current output latch.
- R8: With DIR_MODE=1, a 1 in the direction register makes that pin an output (pad_oe high), and the register resets to all zeros.
- R9: With DIR_MODE=2, a 1 in the direction register makes that pin an input (pad_oe low), and the register resets to all ones.
- R10: With DIR_MODE=0, pad_oe is all ones, a read of offset 0 returns the synchronised pad value for every pin, a read of offset 3 returns zero, and writes to offset 3 are ignored.
- R11: With PIN0_MSB=0, pin n uses register bit n. With PIN0_MSB=1, pin n uses register bit WIDTH-1-n. The same mapping applies to pad_out, pad_oe and pad_in.
- R12: Offsets are data 0, set 1, clear 2 and direction 3. A read of offset 3 returns the stored direction word. bus_rdata is zero whenever no read is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word offset |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, same cycle, zero when idle |
| pad_in | input | WIDTH | Pad input levels, by pin number |
| pad_oe | output | WIDTH | Output enable, by pin number |
| pad_out | output | WIDTH | Output value, by pin number |

## Verification
Two things can happen in the same cycle. A direction write can turn a pin from output to input while that pin's pad level is changing, so the data read must switch from the latch to the synchroniser output exactly two edges after the pad change. The bench runs three builds side by side and drives random pad changes and random register accesses, so direction flips and pad edges often coincide. Each cycle, a behavioural model that tracks the synchroniser stages per bit decides what every read and every pad output should show, and the bench compares the design against it.

// File: rtl/gpio_mmio_ctrl.sv
module gpio_mmio_ctrl #(
  parameter int WIDTH    = 32,
  parameter int SET_MODE = 2,
  parameter int DIR_MODE = 1,
  parameter bit PIN0_MSB = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out
);
  localparam logic [1:0] OFS_DATA = 2'd0;
  localparam logic [1:0] OFS_SET  = 2'd1;
  localparam logic [1:0] OFS_CLR  = 2'd2;
  localparam logic [1:0] OFS_DIR  = 2'd3;
  localparam logic [WIDTH-1:0] DIR_RESET = (DIR_MODE == 2) ? '1 : '0;

  logic [WIDTH-1:0] out_q, dir_q, meta_q, sync_q;
  logic [WIDTH-1:0] pad_bits, oe_bits, data_view;
  logic wr_en, rd_en;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  for (genvar n = 0; n < WIDTH; n++) begin : g_pin
    localparam int B = PIN0_MSB ? (WIDTH - 1 - n) : n;
    assign pad_bits[B] = pad_in[n];
    assign pad_out[n]  = out_q[B];
    assign pad_oe[n]   = oe_bits[B];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_bits;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (wr_en) begin
      unique case (bus_addr)
        OFS_DATA: out_q <= bus_wdata;
        OFS_SET: begin
          if (SET_MODE == 1)      out_q <= bus_wdata;
          else if (SET_MODE == 2) out_q <= out_q | bus_wdata;
        end
        OFS_CLR: begin
          if (SET_MODE == 2) out_q <= out_q & ~bus_wdata;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      dir_q <= DIR_RESET;
    else if (wr_en && bus_addr == OFS_DIR && DIR_MODE != 0)
      dir_q <= bus_wdata;
  end

  assign oe_bits   = (DIR_MODE == 1) ? dir_q : (DIR_MODE == 2) ? ~dir_q : '1;
  assign data_view = (DIR_MODE == 0) ? sync_q
                   : ((oe_bits & out_q) | (~oe_bits & sync_q));

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      unique case (bus_addr)
        OFS_DATA: bus_rdata = data_view;
        OFS_SET,
        OFS_CLR:  bus_rdata = out_q;
        OFS_DIR:  bus_rdata = (DIR_MODE == 0) ? '0 : dir_q;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_mmio_ctrl_chk.sv
module gpio_mmio_ctrl_chk #(
  parameter int WIDTH    = 32,
  parameter int SET_MODE = 2,
  parameter int DIR_MODE = 1,
  parameter bit PIN0_MSB = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] pad_in,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] out_q
);
  logic [1:0] age;
  logic [WIDTH-1:0] pad_as_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  always_comb begin
    for (int n = 0; n < WIDTH; n++)
      pad_as_bits[PIN0_MSB ? (WIDTH - 1 - n) : n] = pad_in[n];
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_out == '0));

  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> $stable(out_q));

  assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (SET_MODE == 2 && bus_sel && bus_wr && bus_addr == 2'd1) |=>
      (((out_q & $past(bus_wdata)) == $past(bus_wdata)) &&
       ((out_q & ~$past(bus_wdata)) == ($past(out_q) & ~$past(bus_wdata)))));

  assert_clr_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (SET_MODE == 2 && bus_sel && bus_wr && bus_addr == 2'd2) |=>
      (((out_q & $past(bus_wdata)) == '0) &&
       ((out_q & ~$past(bus_wdata)) == ($past(out_q) & ~$past(bus_wdata)))));

  assert_oe_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == 2'd3) |=> $stable(pad_oe));

  assert_sync_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (DIR_MODE == 0 && age == 2'd3 && bus_sel && !bus_wr && bus_addr == 2'd0) |->
      (bus_rdata == $past(pad_as_bits, 2)));
endmodule

bind gpio_mmio_ctrl gpio_mmio_ctrl_chk #(
  .WIDTH(WIDTH), .SET_MODE(SET_MODE), .DIR_MODE(DIR_MODE), .PIN0_MSB(PIN0_MSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .out_q(out_q)
);

// File: tb/gpio_mmio_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_mmio_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [63:0] wdata = '0, pad = '0;
  int errors = 0, checks = 0;
  bit done = 1'b0;
  bit first = 1'b1;

  always #2.5 clk = ~clk;

  // three builds: 0 = W32 set/clr, out-polarity, LSB; 1 = W8 set-only, in-polarity, MSB; 2 = W16 no set, no dir
  int cw[3]  = '{32, 8, 16};
  int csm[3] = '{2, 1, 0};
  int cdm[3] = '{1, 2, 0};
  int cms[3] = '{0, 1, 0};

  logic [31:0] rd0, oe0, po0;
  logic [7:0]  rd1, oe1, po1;
  logic [15:0] rd2, oe2, po2;

  gpio_mmio_ctrl #(.WIDTH(32), .SET_MODE(2), .DIR_MODE(1), .PIN0_MSB(1'b0)) u_gpio_mmio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata[31:0]), .bus_rdata(rd0), .pad_in(pad[31:0]), .pad_oe(oe0), .pad_out(po0));
  gpio_mmio_ctrl #(.WIDTH(8), .SET_MODE(1), .DIR_MODE(2), .PIN0_MSB(1'b1)) u_alt (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata[7:0]), .bus_rdata(rd1), .pad_in(pad[7:0]), .pad_oe(oe1), .pad_out(po1));
  gpio_mmio_ctrl #(.WIDTH(16), .SET_MODE(0), .DIR_MODE(0), .PIN0_MSB(1'b0)) u_nodir (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata[15:0]), .bus_rdata(rd2), .pad_in(pad[15:0]), .pad_oe(oe2), .pad_out(po2));

  function automatic logic [63:0] msk(int k);
    return (64'h1 << cw[k]) - 64'h1;
  endfunction

  function automatic logic [63:0] remap(logic [63:0] x, int k);
    logic [63:0] r = '0;
    for (int i = 0; i < cw[k]; i++)
      r[i] = cms[k] ? x[cw[k] - 1 - i] : x[i];
    return r;
  endfunction

  logic [63:0] m_out[3], m_dir[3], m_s1[3], m_s2[3];

  task automatic model_reset();
    for (int k = 0; k < 3; k++) begin
      m_out[k] = '0;
      m_dir[k] = (cdm[k] == 2) ? msk(k) : '0;
      m_s1[k] = '0;
      m_s2[k] = '0;
    end
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      for (int k = 0; k < 3; k++) begin
        logic [63:0] d;
        d = wdata & msk(k);
        m_s2[k] = m_s1[k];
        m_s1[k] = remap(pad & msk(k), k);
        if (sel && wr) begin
          case (addr)
            2'd0: m_out[k] = d;
            2'd1: if (csm[k] == 1) m_out[k] = d;
                  else if (csm[k] == 2) m_out[k] = m_out[k] | d;
            2'd2: if (csm[k] == 2) m_out[k] = m_out[k] & ~d;
            2'd3: if (cdm[k] != 0) m_dir[k] = d;
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(logic [63:0] got, logic [63:0] exp, string tag, int k);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s inst%0d: got %h expected %h", tag, k, got, exp);
    end
  endtask

  task automatic compare();
    for (int k = 0; k < 3; k++) begin
      logic [63:0] oe, rd, g_rd, g_oe, g_po;
      string t_po, t_oe, t_rd;
      oe = (cdm[k] == 1) ? m_dir[k] : (cdm[k] == 2) ? (~m_dir[k] & msk(k)) : msk(k);
      rd = '0;
      t_rd = "R12 idle";
      if (sel && !wr) begin
        case (addr)
          2'd0: begin
            rd = (cdm[k] == 0) ? m_s2[k] : ((oe & m_out[k]) | (~oe & m_s2[k]));
            t_rd = (cdm[k] == 0) ? "R10 data" : "R3 data";
          end
          2'd1, 2'd2: begin rd = m_out[k]; t_rd = "R7 latch"; end
          default: begin
            rd = (cdm[k] == 0) ? '0 : m_dir[k];
            t_rd = (cdm[k] == 0) ? "R10 dir" : "R12 dir";
          end
        endcase
      end
      t_po = (csm[k] == 2) ? "R2 R4 R11" : (csm[k] == 1) ? "R2 R5 R11" : "R2 R6";
      t_oe = (cdm[k] == 1) ? "R8" : (cdm[k] == 2) ? "R9 R11" : "R10";
      if (first) begin t_po = "R1"; t_oe = "R1"; end
      case (k)
        0: begin g_rd = 64'(rd0); g_oe = 64'(oe0); g_po = 64'(po0); end
        1: begin g_rd = 64'(rd1); g_oe = 64'(oe1); g_po = 64'(po1); end
        default: begin g_rd = 64'(rd2); g_oe = 64'(oe2); g_po = 64'(po2); end
      endcase
      chk(g_po, remap(m_out[k], k), t_po, k);
      chk(g_oe, remap(oe, k), t_oe, k);
      chk(g_rd, rd & msk(k), t_rd, k);
    end
    first = 1'b0;
  endtask

  task automatic cyc(bit s, bit w, logic [1:0] a, logic [63:0] d);
    @(negedge clk);
    if (rst_n) compare();
    sel = s; wr = w; addr = a; wdata = d;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0);                        // R1 reset values
    cyc(1, 0, 2'd3, 0);                     // R12 direction reset read
    cyc(1, 1, 2'd3, 64'h0000_00F0_0000_00F0); // R8 R9 direction write
    cyc(1, 1, 2'd0, 64'h0000_0000_A5A5_A5A5); // R2 data load
    cyc(1, 0, 2'd0, 0);                     // R3 mixed read
    cyc(1, 1, 2'd1, 64'h0000_0000_0000_0102); // R4 set / R5 load / R6 ignored
    cyc(1, 1, 2'd2, 64'h0000_0000_0000_0021); // R4 clear / R5 ignored
    cyc(1, 0, 2'd1, 0);                     // R7 latch read
    cyc(1, 0, 2'd2, 0);                     // R7 latch read
    pad = 64'h0000_0000_0000_5A3C;
    cyc(1, 0, 2'd0, 0);                     // R3 synchroniser stage 1
    cyc(1, 0, 2'd0, 0);                     // R3 stage 2
    cyc(1, 0, 2'd0, 0);                     // R3 R10 R11 value visible
    cyc(1, 1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF); // R10 ignored in no-dir build
    cyc(1, 0, 2'd3, 0);
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 4) == 0) pad = {$urandom, $urandom};
      cyc(($urandom % 10) < 7, $urandom % 2, 2'($urandom % 4), {$urandom, $urandom});
      if (($urandom % 500) == 0) begin
        @(negedge clk); rst_n = 1'b0; sel = 1'b0;
        @(negedge clk); rst_n = 1'b1; first = 1'b1;
      end
    end
    cyc(0, 0, 0, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule